// File: doc/BRIEF.md
# Nibble Accumulator Datapath

This block is the arithmetic core of a small 4-bit controller. It holds two working nibbles, an accumulator (A) and a secondary register (B), plus a carry flag (C) and a status flag (S). Each clock edge applies the operation named by a single 5-bit select. The operation may read a 4-bit immediate, a memory nibble supplied by the surrounding sequencer, a Y index nibble and a 2-bit bit index.

The results land in A, B, C and S on the same edge. Bit set and bit clear instead produce a modified nibble and a write strobe on combinational outputs, in the cycle the operation is presented. The surrounding logic stores that nibble at whatever address it is currently pointing to. Address generation, program sequencing and memory storage all live outside this block.

The command input is a plain per-cycle select and has no valid/ready pair. The block accepts one operation on every edge and never stalls, so there is no back-pressure to manage. Selecting the idle code holds all state.

Top module: `nib_acc_dp`

## Requirements
- R1: Add-immediate (code 3) and add-memory (code 4) leave (A + operand) mod 16 in A and set S to the carry out. C is not changed.
- R2: Add-with-carry (code 5) leaves (M + A + C) mod 16 in A, and C and S both take the carry out.
- R3: Subtract-with-carry (code 6) leaves (M − A − (1 − C)) mod 16 in A, and C and S both become 1 exactly when the true result is not negative.
- R4: Decimal adjust after add (code 7) acts only when C=1 or A>9. It then sets A to (A+6) mod 16 and C to 1. Otherwise A, B, C and S are kept.
- R5: Decimal adjust after subtract (code 8) acts only when C=0 or A>9. It then sets A to (A+10) mod 16 and clears C. Otherwise everything is kept.
- R6: Rotate left (code 12) shifts A up by one bit, moving C into A bit 0 and the old A bit 3 into C. Rotate right (code 13) moves C into A bit 3 and the old A bit 0 into C. S is kept.
- R7: Increment B (code 14) and decrement B (code 15) wrap modulo 16. Increment sets S to 1 unless the new B is 0. Decrement sets S to 1 unless the new B is 15.
- R8: The compare codes set S and change nothing else. Codes 19–22 test inequality: memory against immediate, Y against immediate, A against memory and B against memory. Codes 23–25 test unsigned less-or-equal: A against immediate, A against memory and B against memory.
- R9: Bit set (26) and bit clear (27) raise the write strobe and output the memory nibble with bit number `bit_sel_i` forced to 1 or 0. Bit test (28) copies that bit into S and leaves the strobe low. The strobe is low for every other code.
- R10: Negate (9) writes (16 − A) mod 16 into A. Complement (10) inverts B. OR (11) writes A|B into A. None of the three alters C or S.
- R11: While `rst_n` is low, A, B and C are 0 and S is 1.
- R12: Code 16 sets C, code 17 clears C, and code 18 copies C into S. Code 1 loads the immediate into A and code 2 loads it into B. Code 0 and the unused codes 29–31 hold all state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation select, applied at the next edge |
| imm_i | input | 4 | Immediate operand |
| mem_i | input | 4 | Memory nibble at the current address |
| y_i | input | 4 | Y index nibble, used by the Y compare |
| bit_sel_i | input | 2 | Bit index for bit set, clear and test |
| a_o | output | 4 | Accumulator A |
| b_o | output | 4 | Register B |
| c_o | output | 1 | Carry flag |
| s_o | output | 1 | Status flag |
| wr_en_o | output | 1 | Memory write strobe for bit set and bit clear |
| wr_data_o | output | 4 | Nibble to write back to memory |

## Verification
The assertions assume that `op_i` and the operand inputs are stable and known around each rising edge. They also assume that `mem_i` reflects the addressed nibble throughout the cycle, because the write-back check compares `wr_data_o` against it.

The stimulus drives every input on the falling edge only. It presets A, B, C and S through the block's own load and flag codes, then applies each of the 32 operation codes. The sweep covers every A value, sixteen operand patterns and both carry states, so the decimal-adjust thresholds and both ends of each wrap are reached.

// File: rtl/nib_acc_pkg.sv
package nib_acc_pkg;
  localparam int NIB_W = 4;
  localparam int OP_W  = 5;
  localparam int BIX_W = 2;
  localparam logic [NIB_W-1:0] DEC_LIMIT = 4'd9;
  localparam logic [NIB_W-1:0] ADD_FIX   = 4'd6;
  localparam logic [NIB_W-1:0] SUB_FIX   = 4'd10;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 5'd0,  OP_LDA_I = 5'd1,  OP_LDB_I = 5'd2,  OP_ADD_I = 5'd3,
    OP_ADD_M = 5'd4,  OP_ADC   = 5'd5,  OP_SBC   = 5'd6,  OP_DADJA = 5'd7,
    OP_DADJS = 5'd8,  OP_NEG   = 5'd9,  OP_CPLB  = 5'd10, OP_OR    = 5'd11,
    OP_ROL   = 5'd12, OP_ROR   = 5'd13, OP_INCB  = 5'd14, OP_DECB  = 5'd15,
    OP_SETC  = 5'd16, OP_CLRC  = 5'd17, OP_TSTC  = 5'd18, OP_NE_MI = 5'd19,
    OP_NE_YI = 5'd20, OP_NE_AM = 5'd21, OP_NE_BM = 5'd22, OP_LE_AI = 5'd23,
    OP_LE_AM = 5'd24, OP_LE_BM = 5'd25, OP_BSET  = 5'd26, OP_BCLR  = 5'd27,
    OP_BTST  = 5'd28
  } nib_op_e;

  typedef struct packed {
    logic [NIB_W-1:0] a;
    logic [NIB_W-1:0] b;
    logic             c;
    logic             s;
  } nib_state_t;
endpackage

// File: rtl/nib_arith_unit.sv
module nib_arith_unit
  import nib_acc_pkg::*;
(
  input  nib_op_e          op,
  input  nib_state_t       cur,
  input  logic [NIB_W-1:0] imm,
  input  logic [NIB_W-1:0] mem,
  output nib_state_t       nxt,
  output logic             hit
);
  localparam int EXT_W = NIB_W + 1;

  logic [EXT_W-1:0] sum_i, sum_m, sum_c, dif_c;
  logic [NIB_W-1:0] b_inc, b_dec;
  logic             dec_big;

  always_comb begin
    sum_i   = {1'b0, cur.a} + {1'b0, imm};
    sum_m   = {1'b0, cur.a} + {1'b0, mem};
    sum_c   = {1'b0, mem} + {1'b0, cur.a} + {{NIB_W{1'b0}}, cur.c};
    dif_c   = {1'b0, mem} - {1'b0, cur.a} - {{NIB_W{1'b0}}, ~cur.c};
    b_inc   = cur.b + 1'b1;
    b_dec   = cur.b - 1'b1;
    dec_big = (cur.a > DEC_LIMIT);
  end

  always_comb begin
    nxt = cur;
    hit = 1'b1;
    unique case (op)
      OP_LDA_I: nxt.a = imm;
      OP_LDB_I: nxt.b = imm;
      OP_ADD_I: begin
        nxt.a = sum_i[NIB_W-1:0];
        nxt.s = sum_i[NIB_W];
      end
      OP_ADD_M: begin
        nxt.a = sum_m[NIB_W-1:0];
        nxt.s = sum_m[NIB_W];
      end
      OP_ADC: begin
        nxt.a = sum_c[NIB_W-1:0];
        nxt.c = sum_c[NIB_W];
        nxt.s = sum_c[NIB_W];
      end
      OP_SBC: begin
        nxt.a = dif_c[NIB_W-1:0];
        nxt.c = ~dif_c[NIB_W];
        nxt.s = ~dif_c[NIB_W];
      end
      OP_DADJA: begin
        if (cur.c || dec_big) begin
          nxt.a = cur.a + ADD_FIX;
          nxt.c = 1'b1;
        end
      end
      OP_DADJS: begin
        if (!cur.c || dec_big) begin
          nxt.a = cur.a + SUB_FIX;
          nxt.c = 1'b0;
        end
      end
      OP_NEG:  nxt.a = ~cur.a + 1'b1;
      OP_CPLB: nxt.b = ~cur.b;
      OP_OR:   nxt.a = cur.a | cur.b;
      OP_ROL: begin
        nxt.a = {cur.a[NIB_W-2:0], cur.c};
        nxt.c = cur.a[NIB_W-1];
      end
      OP_ROR: begin
        nxt.a = {cur.c, cur.a[NIB_W-1:1]};
        nxt.c = cur.a[0];
      end
      OP_INCB: begin
        nxt.b = b_inc;
        nxt.s = (b_inc != '0);
      end
      OP_DECB: begin
        nxt.b = b_dec;
        nxt.s = (b_dec != '1);
      end
      OP_SETC: nxt.c = 1'b1;
      OP_CLRC: nxt.c = 1'b0;
      OP_TSTC: nxt.s = cur.c;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_cmp_unit.sv
module nib_cmp_unit
  import nib_acc_pkg::*;
(
  input  nib_op_e          op,
  input  nib_state_t       cur,
  input  logic [NIB_W-1:0] imm,
  input  logic [NIB_W-1:0] mem,
  input  logic [NIB_W-1:0] y,
  output logic             s_val,
  output logic             hit
);
  always_comb begin
    hit   = 1'b1;
    s_val = cur.s;
    unique case (op)
      OP_NE_MI: s_val = (mem != imm);
      OP_NE_YI: s_val = (y != imm);
      OP_NE_AM: s_val = (cur.a != mem);
      OP_NE_BM: s_val = (cur.b != mem);
      OP_LE_AI: s_val = (cur.a <= imm);
      OP_LE_AM: s_val = (cur.a <= mem);
      OP_LE_BM: s_val = (cur.b <= mem);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_bit_unit.sv
module nib_bit_unit
  import nib_acc_pkg::*;
(
  input  nib_op_e          op,
  input  logic [NIB_W-1:0] mem,
  input  logic [BIX_W-1:0] bsel,
  output logic             wr_en,
  output logic [NIB_W-1:0] wr_data,
  output logic             s_val,
  output logic             hit
);
  logic [NIB_W-1:0] mask;

  always_comb begin
    mask    = '0;
    mask[bsel] = 1'b1;
    wr_en   = 1'b0;
    wr_data = mem;
    s_val   = mem[bsel];
    hit     = 1'b0;
    unique case (op)
      OP_BSET: begin
        wr_en   = 1'b1;
        wr_data = mem | mask;
      end
      OP_BCLR: begin
        wr_en   = 1'b1;
        wr_data = mem & ~mask;
      end
      OP_BTST: hit = 1'b1;
      default: ;
    endcase
    // R9: a write-back never disturbs more than the selected bit
    if (wr_en) begin
      p_one_bit_r9: assert ($countones(wr_data ^ mem) <= 1);
    end
  end
endmodule

// File: rtl/nib_acc_dp.sv
module nib_acc_dp
  import nib_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_i,
  input  logic [NIB_W-1:0] imm_i,
  input  logic [NIB_W-1:0] mem_i,
  input  logic [NIB_W-1:0] y_i,
  input  logic [BIX_W-1:0] bit_sel_i,
  output logic [NIB_W-1:0] a_o,
  output logic [NIB_W-1:0] b_o,
  output logic             c_o,
  output logic             s_o,
  output logic             wr_en_o,
  output logic [NIB_W-1:0] wr_data_o
);
  nib_op_e    op;
  nib_state_t cur, nxt, ar_nxt;
  logic       ar_hit, cm_hit, bt_hit, cm_s, bt_s;

  assign op = nib_op_e'(op_i);

  nib_arith_unit u_arith (
    .op(op), .cur(cur), .imm(imm_i), .mem(mem_i), .nxt(ar_nxt), .hit(ar_hit)
  );

  nib_cmp_unit u_cmp (
    .op(op), .cur(cur), .imm(imm_i), .mem(mem_i), .y(y_i),
    .s_val(cm_s), .hit(cm_hit)
  );

  nib_bit_unit u_bit (
    .op(op), .mem(mem_i), .bsel(bit_sel_i), .wr_en(wr_en_o),
    .wr_data(wr_data_o), .s_val(bt_s), .hit(bt_hit)
  );

  always_comb begin
    nxt = cur;
    if (ar_hit)      nxt = ar_nxt;
    else if (cm_hit) nxt.s = cm_s;
    else if (bt_hit) nxt.s = bt_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '{a: '0, b: '0, c: 1'b0, s: 1'b1};
    else        cur <= nxt;
  end

  assign a_o = cur.a;
  assign b_o = cur.b;
  assign c_o = cur.c;
  assign s_o = cur.s;

  // R1: plain additions leave the carry alone
  p_add_keeps_c_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD_I || op_i == OP_ADD_M) |=> (c_o == $past(c_o)));
  // R2: carry and status agree after add with carry
  p_adc_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADC) |=> (c_o == s_o));
  // R3: carry and status agree after subtract with carry
  p_sbc_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SBC) |=> (c_o == s_o));
  // R4: an acting add adjust always leaves carry set
  p_dadja_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DADJA && (c_o || a_o > DEC_LIMIT)) |=> c_o);
  // R5: an acting subtract adjust always leaves carry clear
  p_dadjs_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DADJS && (!c_o || a_o > DEC_LIMIT)) |=> !c_o);
  // R6: rotate left moves the old top bit into carry
  p_rol_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ROL) |=> (c_o == $past(a_o[NIB_W-1])));
  // R8: compares leave A, B and C untouched
  p_cmp_only_s_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_NE_MI && op_i <= OP_LE_BM) |=> ($stable(a_o) && $stable(b_o) && $stable(c_o)));
  // R10: negate, complement and OR keep both flags
  p_logic_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG || op_i == OP_CPLB || op_i == OP_OR) |=> ($stable(c_o) && $stable(s_o)));
  // R9: the write strobe appears only for bit set or clear
  p_wr_only_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (op_i == OP_BSET || op_i == OP_BCLR));
endmodule

// File: tb/tb_nib_acc_dp.sv
module tb_nib_acc_dp;
  import nib_acc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic [3:0] imm_i = '0, mem_i = '0, y_i = '0;
  logic [1:0] bit_sel_i = '0;
  logic [3:0] a_o, b_o, wr_data_o;
  logic c_o, s_o, wr_en_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nib_acc_dp dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .mem_i(mem_i),
    .y_i(y_i), .bit_sel_i(bit_sel_i), .a_o(a_o), .b_o(b_o), .c_o(c_o),
    .s_o(s_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string tag_of(int op);
    case (op)
      3, 4:   return "R1";
      5:      return "R2";
      6:      return "R3";
      7:      return "R4";
      8:      return "R5";
      12, 13: return "R6";
      14, 15: return "R7";
      9, 10, 11: return "R10";
      19, 20, 21, 22, 23, 24, 25: return "R8";
      26, 27, 28: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic predict(input int op, a, b, c, s, imm, mem, y, bs,
                         output int ea, eb, ec, es, ewe, ewd);
    int t;
    ea = a; eb = b; ec = c; es = s; ewe = 0; ewd = 0;
    case (op)
      1: ea = imm;
      2: eb = imm;
      3: begin t = a + imm; ea = t % 16; es = (t > 15); end
      4: begin t = a + mem; ea = t % 16; es = (t > 15); end
      5: begin t = mem + a + c; ea = t % 16; ec = (t > 15); es = ec; end
      6: begin t = mem - a - (1 - c); ea = (t + 32) % 16; ec = (t >= 0); es = ec; end
      7: if (c == 1 || a > 9) begin ea = (a + 6) % 16; ec = 1; end
      8: if (c == 0 || a > 9) begin ea = (a + 10) % 16; ec = 0; end
      9: ea = (16 - a) % 16;
      10: eb = 15 - b;
      11: ea = a | b;
      12: begin ea = (a * 2 + c) % 16; ec = (a >= 8); end
      13: begin ea = a / 2 + c * 8; ec = a % 2; end
      14: begin eb = (b + 1) % 16; es = (eb != 0); end
      15: begin eb = (b + 15) % 16; es = (eb != 15); end
      16: ec = 1;
      17: ec = 0;
      18: es = c;
      19: es = (mem != imm);
      20: es = (y != imm);
      21: es = (a != mem);
      22: es = (b != mem);
      23: es = (a <= imm);
      24: es = (a <= mem);
      25: es = (b <= mem);
      26: begin ewe = 1; ewd = mem | (1 << bs); end
      27: begin ewe = 1; ewd = mem & (15 - (1 << bs)); end
      28: es = (mem >> bs) % 2;
      default: ;
    endcase
  endtask

  task automatic step(input int op, input int imm, input int mem, input int y, input int bs);
    op_i = op[4:0]; imm_i = imm[3:0]; mem_i = mem[3:0]; y_i = y[3:0]; bit_sel_i = bs[1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int ea, eb, ec, es, ewe, ewd;
    repeat (3) @(negedge clk);
    checks++;
    if (a_o !== 4'd0 || b_o !== 4'd0 || c_o !== 1'b0 || s_o !== 1'b1) begin
      failures++;
      $display("FAIL R11 reset state got a=%0d b=%0d c=%0d s=%0d exp 0 0 0 1", a_o, b_o, c_o, s_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R11: state must still be the reset state one idle cycle after release
    checks++;
    if (a_o !== 4'd0 || b_o !== 4'd0 || c_o !== 1'b0 || s_o !== 1'b1) begin
      failures++;
      $display("FAIL R11 after release got a=%0d b=%0d c=%0d s=%0d exp 0 0 0 1", a_o, b_o, c_o, s_o);
    end

    for (int op = 0; op < 32; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int m = 0; m < 16; m++) begin
          for (int c = 0; c < 2; c++) begin
            int b, s, imm, y, bs;
            b   = (a + m * 3) % 16;
            s   = c ^ (a % 2);
            imm = (m * 7 + 3) % 16;
            y   = (m + a) % 16;
            bs  = (a ^ m) % 4;
            step(1, a, 0, 0, 0);
            step(2, b, 0, 0, 0);
            step(s == 1 ? 16 : 17, 0, 0, 0, 0);
            step(18, 0, 0, 0, 0);
            step(c == 1 ? 16 : 17, 0, 0, 0, 0);
            predict(op, a, b, c, s, imm, m, y, bs, ea, eb, ec, es, ewe, ewd);
            op_i = op[4:0]; imm_i = imm[3:0]; mem_i = m[3:0]; y_i = y[3:0]; bit_sel_i = bs[1:0];
            #1;
            checks++;
            if (wr_en_o !== ewe[0] || (ewe == 1 && wr_data_o !== ewd[3:0])) begin
              failures++;
              $display("FAIL %s write-back op=%0d got we=%0d wd=%0d exp we=%0d wd=%0d",
                       (op >= 26 && op <= 28) ? "R9" : tag_of(op), op, wr_en_o, wr_data_o, ewe, ewd);
            end
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (a_o !== ea[3:0] || b_o !== eb[3:0] || c_o !== ec[0] || s_o !== es[0]) begin
              failures++;
              $display("FAIL %s op=%0d a=%0d b=%0d c=%0d s=%0d m=%0d i=%0d got %0d %0d %0d %0d exp %0d %0d %0d %0d",
                       tag_of(op), op, a, b, c, s, m, imm, a_o, b_o, c_o, s_o, ea, eb, ec, es);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule